// File: doc/BRIEF.md
# Interrupt-Triggered Peripheral Microsequencer

This block stands in for a general-purpose processor on the routine work of a low-power sensor node. Each interrupt line is tied to a short command routine held in shared memory. When a line pulses, the sequencer reads that line's entry from a vector table in memory, jumps to the address it finds there, and runs commands until one ends the routine. The commands turn peripheral power domains on or off, copy a counted block of words from one device address to another, and write an immediate control word to a device.

All memory and device traffic goes through one bus master port. Requests use a valid/ready handshake. While `bus_req_valid` is high and `bus_req_ready` is low, the request fields are held constant, and the target may stall for any number of cycles. A read then completes when the target returns a single `bus_rsp_valid` beat. Only one read is outstanding at a time, and the sequencer is always able to accept that beat. A write completes at its request handshake. Interrupt lines, power enables and the busy and error flags are plain signals.

The opcode is carried in bits [15:13] of an instruction word. Operands sit in the low bits. A transfer or immediate write is followed by two operand words in the instruction stream.

Top module: `evt_microseq`

## Requirements
- R1: During and immediately after reset, all `pwr_en` bits, `busy`, `err` and `bus_req_valid` are 0.
- R2: A one-cycle high on `irq[i]` latches a pending request. Servicing it reads the word at address VEC_BASE+i (VEC_BASE defaults to 0) and starts fetching instructions at the address held in that word.
- R3: When several requests are pending while idle, the lowest index is serviced first. A running routine is never interrupted. Requests that arrive during a routine are kept and serviced afterwards, again lowest index first.
- R4: Opcode 1 (power-on) sets `pwr_en[d]` and opcode 2 (power-off) clears it, where d is the instruction's low 3 bits. Other enables are unchanged, and every enable holds its value across routines.
- R5: Opcode 4 (transfer) takes a word count N from bits [12:0], followed by a source address word and a destination address word. It performs N pairs of bus operations, each a read of the source followed by a write of the data just read to the destination. Both addresses stay fixed for the whole transfer.
- R6: A transfer with N = 0 performs no reads of the source and no data writes. Execution continues with the next instruction.
- R7: Opcode 5 (immediate write) is followed by a destination address word and a data word. It performs one bus write of that data to that address.
- R8: Opcode 0 ends the routine. `busy` then falls, and any instruction after it is never executed.
- R9: Opcodes 3, 6 and 7 end the routine like opcode 0 and set `err`. Instructions after the bad opcode are not executed. `err` stays set until the next routine starts.
- R10: A request with `bus_req_valid` high and `bus_req_ready` low keeps its address, direction and write data unchanged in the next cycle. Requests are only issued while `busy` is high.
- R11: At most one power enable changes in any cycle, and none changes in a cycle that follows an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq | input | NUM_IRQ (4) | Interrupt request pulses |
| bus_req_valid | output | 1 | Bus request valid |
| bus_req_ready | input | 1 | Bus request accepted |
| bus_req_we | output | 1 | 1 = write, 0 = read |
| bus_req_addr | output | ADDR_W (16) | Request address |
| bus_req_wdata | output | DATA_W (16) | Write data |
| bus_rsp_valid | input | 1 | Read data beat |
| bus_rsp_rdata | input | DATA_W (16) | Read data |
| pwr_en | output | NUM_DEV (8) | Peripheral power enables |
| busy | output | 1 | A routine is being fetched or executed |
| err | output | 1 | Last routine ended on an undefined opcode |

## Verification
The bench sweeps transfer counts from 0 to 6 under random stalls and response delays. A counter that is off by one would show up as a missing or extra sink write, and a zero count that still reads the source would show up as an extra read. It walks every power enable on and then off. A decoder that picks the wrong bit, or that disturbs a neighbouring bit, would show the wrong mask. It fires simultaneous interrupts, and interrupts in the middle of a routine, to catch the wrong priority order, preemption, or lost requests. Each reserved opcode is placed before a power-on that must never run, and `err` is checked again after the next clean routine to catch a flag that never clears.

// File: rtl/evt_microseq_pkg.sv
package evt_microseq_pkg;
  typedef enum logic [2:0] {
    OP_END     = 3'd0,
    OP_PWR_ON  = 3'd1,
    OP_PWR_OFF = 3'd2,
    OP_RSV3    = 3'd3,
    OP_XFER    = 3'd4,
    OP_WRIMM   = 3'd5,
    OP_RSV6    = 3'd6,
    OP_RSV7    = 3'd7
  } opcode_e;

  typedef enum logic [2:0] {
    RD_VEC, RD_INSN, RD_ARG1, RD_ARG2, RD_DATA
  } rd_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RREQ, ST_RWAIT, ST_EXEC, ST_ARGS, ST_WREQ
  } state_e;
endpackage

// File: rtl/evt_irq_arb.sv
module evt_irq_arb #(
  parameter int NUM_IRQ = 4,
  localparam int IRQ_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq,
  input  logic               take,
  output logic               any,
  output logic [IRQ_W-1:0]   sel
);
  logic [NUM_IRQ-1:0] pend_q;
  logic [NUM_IRQ-1:0] clr_mask;

  // lowest index wins: scan from the top so the last hit is the smallest
  always_comb begin
    sel = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (pend_q[i]) sel = IRQ_W'(i);
    end
  end

  assign any = |pend_q;

  always_comb begin
    for (int i = 0; i < NUM_IRQ; i++) begin
      clr_mask[i] = take && (sel == IRQ_W'(i));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_mask) | irq;
  end
endmodule

// File: rtl/evt_pwr_bank.sv
module evt_pwr_bank #(
  parameter int NUM_DEV = 8,
  localparam int DEV_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               on_stb,
  input  logic               off_stb,
  input  logic [DEV_W-1:0]   dev,
  output logic [NUM_DEV-1:0] pwr_en
);
  for (genvar g = 0; g < NUM_DEV; g++) begin : g_dom
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pwr_en[g] <= 1'b0;
      end else if (dev == DEV_W'(g)) begin
        if (on_stb)       pwr_en[g] <= 1'b1;
        else if (off_stb) pwr_en[g] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/evt_seq_ctrl.sv
module evt_seq_ctrl
  import evt_microseq_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int NUM_IRQ = 4,
  parameter int NUM_DEV = 8,
  parameter logic [ADDR_W-1:0] VEC_BASE = '0,
  localparam int IRQ_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1,
  localparam int DEV_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
  localparam int CNT_W = DATA_W - 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arb_any,
  input  logic [IRQ_W-1:0]  arb_sel,
  output logic              arb_take,
  output logic              bus_req_valid,
  input  logic              bus_req_ready,
  output logic              bus_req_we,
  output logic [ADDR_W-1:0] bus_req_addr,
  output logic [DATA_W-1:0] bus_req_wdata,
  input  logic              bus_rsp_valid,
  input  logic [DATA_W-1:0] bus_rsp_rdata,
  output logic              pwr_on_stb,
  output logic              pwr_off_stb,
  output logic [DEV_W-1:0]  pwr_dev,
  output logic              busy,
  output logic              err
);
  state_e            state_q;
  rd_kind_e          kind_q;
  logic [ADDR_W-1:0] pc_q;
  logic [DATA_W-1:0] ir_q;
  logic [DATA_W-1:0] arg1_q;
  logic [DATA_W-1:0] arg2_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              err_q;
  opcode_e           op;

  assign op            = opcode_e'(ir_q[DATA_W-1 -: 3]);
  assign arb_take      = (state_q == ST_IDLE) && arb_any;
  assign bus_req_valid = (state_q == ST_RREQ) || (state_q == ST_WREQ);
  assign bus_req_we    = (state_q == ST_WREQ);
  assign bus_req_addr  = addr_q;
  assign bus_req_wdata = wdata_q;
  assign pwr_on_stb    = (state_q == ST_EXEC) && (op == OP_PWR_ON);
  assign pwr_off_stb   = (state_q == ST_EXEC) && (op == OP_PWR_OFF);
  assign pwr_dev       = ir_q[DEV_W-1:0];
  assign busy          = (state_q != ST_IDLE);
  assign err           = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kind_q  <= RD_VEC;
      pc_q    <= '0;
      ir_q    <= '0;
      arg1_q  <= '0;
      arg2_q  <= '0;
      cnt_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (arb_any) begin
            err_q   <= 1'b0;
            addr_q  <= VEC_BASE + ADDR_W'(arb_sel);
            kind_q  <= RD_VEC;
            state_q <= ST_RREQ;
          end
        end
        ST_RREQ: begin
          if (bus_req_ready) state_q <= ST_RWAIT;
        end
        ST_RWAIT: begin
          if (bus_rsp_valid) begin
            unique case (kind_q)
              RD_VEC: begin
                pc_q    <= ADDR_W'(bus_rsp_rdata);
                addr_q  <= ADDR_W'(bus_rsp_rdata);
                kind_q  <= RD_INSN;
                state_q <= ST_RREQ;
              end
              RD_INSN: begin
                ir_q    <= bus_rsp_rdata;
                pc_q    <= pc_q + 1'b1;
                state_q <= ST_EXEC;
              end
              RD_ARG1: begin
                arg1_q  <= bus_rsp_rdata;
                pc_q    <= pc_q + 1'b1;
                addr_q  <= pc_q + 1'b1;
                kind_q  <= RD_ARG2;
                state_q <= ST_RREQ;
              end
              RD_ARG2: begin
                arg2_q  <= bus_rsp_rdata;
                pc_q    <= pc_q + 1'b1;
                state_q <= ST_ARGS;
              end
              default: begin
                wdata_q <= bus_rsp_rdata;
                addr_q  <= ADDR_W'(arg2_q);
                state_q <= ST_WREQ;
              end
            endcase
          end
        end
        ST_EXEC: begin
          unique case (op)
            OP_END: state_q <= ST_IDLE;
            OP_PWR_ON, OP_PWR_OFF: begin
              addr_q  <= pc_q;
              kind_q  <= RD_INSN;
              state_q <= ST_RREQ;
            end
            OP_XFER, OP_WRIMM: begin
              cnt_q   <= ir_q[CNT_W-1:0];
              addr_q  <= pc_q;
              kind_q  <= RD_ARG1;
              state_q <= ST_RREQ;
            end
            default: begin
              err_q   <= 1'b1;
              state_q <= ST_IDLE;
            end
          endcase
        end
        ST_ARGS: begin
          if (op == OP_XFER) begin
            if (cnt_q == '0) begin
              addr_q <= pc_q;
              kind_q <= RD_INSN;
            end else begin
              addr_q <= ADDR_W'(arg1_q);
              kind_q <= RD_DATA;
            end
            state_q <= ST_RREQ;
          end else begin
            addr_q  <= ADDR_W'(arg1_q);
            wdata_q <= arg2_q;
            state_q <= ST_WREQ;
          end
        end
        default: begin
          if (bus_req_ready) begin
            if (op == OP_XFER && cnt_q > CNT_W'(1)) begin
              cnt_q  <= cnt_q - 1'b1;
              addr_q <= ADDR_W'(arg1_q);
              kind_q <= RD_DATA;
            end else begin
              addr_q <= pc_q;
              kind_q <= RD_INSN;
            end
            state_q <= ST_RREQ;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/evt_microseq.sv
module evt_microseq #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int NUM_IRQ = 4,
  parameter int NUM_DEV = 8,
  parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq,
  output logic               bus_req_valid,
  input  logic               bus_req_ready,
  output logic               bus_req_we,
  output logic [ADDR_W-1:0]  bus_req_addr,
  output logic [DATA_W-1:0]  bus_req_wdata,
  input  logic               bus_rsp_valid,
  input  logic [DATA_W-1:0]  bus_rsp_rdata,
  output logic [NUM_DEV-1:0] pwr_en,
  output logic               busy,
  output logic               err
);
  localparam int IRQ_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
  localparam int DEV_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;

  logic             arb_any;
  logic             arb_take;
  logic [IRQ_W-1:0] arb_sel;
  logic             on_stb;
  logic             off_stb;
  logic [DEV_W-1:0] dev;

  evt_irq_arb #(.NUM_IRQ(NUM_IRQ)) u_arb (
    .clk(clk), .rst_n(rst_n), .irq(irq),
    .take(arb_take), .any(arb_any), .sel(arb_sel)
  );

  evt_seq_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_IRQ(NUM_IRQ),
    .NUM_DEV(NUM_DEV), .VEC_BASE(VEC_BASE)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .arb_any(arb_any), .arb_sel(arb_sel), .arb_take(arb_take),
    .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready),
    .bus_req_we(bus_req_we), .bus_req_addr(bus_req_addr),
    .bus_req_wdata(bus_req_wdata), .bus_rsp_valid(bus_rsp_valid),
    .bus_rsp_rdata(bus_rsp_rdata),
    .pwr_on_stb(on_stb), .pwr_off_stb(off_stb), .pwr_dev(dev),
    .busy(busy), .err(err)
  );

  evt_pwr_bank #(.NUM_DEV(NUM_DEV)) u_pwr (
    .clk(clk), .rst_n(rst_n), .on_stb(on_stb), .off_stb(off_stb),
    .dev(dev), .pwr_en(pwr_en)
  );
endmodule

// File: rtl/evt_microseq_chk.sv
module evt_microseq_chk #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int NUM_DEV = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_req_valid,
  input logic               bus_req_ready,
  input logic               bus_req_we,
  input logic [ADDR_W-1:0]  bus_req_addr,
  input logic [DATA_W-1:0]  bus_req_wdata,
  input logic [NUM_DEV-1:0] pwr_en,
  input logic               busy,
  input logic               err
);
  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && !bus_req_ready |=> bus_req_valid && $stable(bus_req_addr)
      && $stable(bus_req_we) && $stable(bus_req_wdata));

  // R10
  req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid |-> busy);

  // R11
  pwr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pwr_en ^ $past(pwr_en)) <= 1);

  // R11
  pwr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(pwr_en));

  // R9
  err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(busy) && !busy);
endmodule

bind evt_microseq evt_microseq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_DEV(NUM_DEV)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req_valid(bus_req_valid),
  .bus_req_ready(bus_req_ready), .bus_req_we(bus_req_we),
  .bus_req_addr(bus_req_addr), .bus_req_wdata(bus_req_wdata),
  .pwr_en(pwr_en), .busy(busy), .err(err)
);

// File: tb/test_evt_microseq.sv
`timescale 1ns/1ps
module test_evt_microseq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  irq = '0;
  logic        bus_req_valid, bus_req_we, bus_rsp_valid;
  logic        bus_req_ready;
  logic [15:0] bus_req_addr, bus_req_wdata, bus_rsp_rdata;
  logic [7:0]  pwr_en;
  logic        busy, err;

  always #2 clk = ~clk;

  evt_microseq i_evt_microseq (
    .clk(clk), .rst_n(rst_n), .irq(irq),
    .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready),
    .bus_req_we(bus_req_we), .bus_req_addr(bus_req_addr),
    .bus_req_wdata(bus_req_wdata), .bus_rsp_valid(bus_rsp_valid),
    .bus_rsp_rdata(bus_rsp_rdata), .pwr_en(pwr_en), .busy(busy), .err(err)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // memory and device model: 0x300 source, 0x301/0x302 sinks
  logic [15:0] mem [0:511];
  logic [15:0] log_a [0:63];
  logic [15:0] log_d [0:63];
  int          log_n = 0;
  logic [15:0] src_seq = 16'h1000;
  int          src_reads = 0;
  logic        rdy = 1'b0, rsp_v = 1'b0;
  logic [15:0] rsp_d = '0, pend_d = '0;
  bit          pend = 0;
  int          lat = 0;
  logic [7:0]  lfsr = 8'h5B;
  logic        p_v = 0, p_we = 0;
  logic [15:0] p_a = '0, p_wd = '0;

  assign bus_req_ready = rdy;
  assign bus_rsp_valid = rsp_v;
  assign bus_rsp_rdata = rsp_d;

  always @(negedge clk) begin
    if (!rst_n) begin
      rdy = 0; rsp_v = 0; pend = 0; p_v = 0;
    end else begin
      rsp_v = 0;
      if (p_v && rdy) begin
        if (p_we) begin
          if (log_n < 64) begin log_a[log_n] = p_a; log_d[log_n] = p_wd; end
          log_n++;
        end else begin
          if (p_a == 16'h0300) begin
            pend_d = src_seq; src_seq = src_seq + 1; src_reads++;
          end else pend_d = mem[p_a[8:0]];
          pend = 1; lat = int'(lfsr[2:1]) % 3;
        end
      end
      if (pend) begin
        if (lat == 0) begin rsp_v = 1; rsp_d = pend_d; pend = 0; end
        else lat--;
      end
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      rdy = lfsr[0] | lfsr[2];
      p_v = bus_req_valid; p_we = bus_req_we; p_a = bus_req_addr; p_wd = bus_req_wdata;
    end
  end

  function automatic logic [15:0] enc(input int op, input int opd);
    return {op[2:0], opd[12:0]};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic fire(input logic [3:0] m);
    @(negedge clk) irq = m;
    @(negedge clk) irq = '0;
  endtask

  task automatic wait_idle();
    int quiet = 0;
    while (quiet < 6) begin
      @(negedge clk);
      quiet = busy ? 0 : quiet + 1;
    end
  endtask

  task automatic clear_log();
    log_n = 0; src_reads = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0]  exp_pwr;
    logic [15:0] s0;
    logic [15:0] ids [0:3];
    for (int i = 0; i < 512; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 pwr_en", pwr_en, 0);
    chk("R1 busy", busy, 0);
    chk("R1 err", err, 0);
    chk("R1 valid", bus_req_valid, 0);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    chk("R1 busy after release", busy, 0);

    // R2 R4 R5 R7 R8: irq 0 routine
    mem[0] = 16'h0020;
    mem[16'h20] = enc(1, 2);
    mem[16'h21] = enc(4, 3); mem[16'h22] = 16'h0300; mem[16'h23] = 16'h0301;
    mem[16'h24] = enc(5, 0); mem[16'h25] = 16'h0302; mem[16'h26] = 16'hBEEF;
    mem[16'h27] = enc(0, 0);
    mem[16'h28] = enc(1, 7);
    clear_log(); s0 = src_seq;
    fire(4'b0001); wait_idle();
    chk("R5 write count", log_n, 4);
    for (int k = 0; k < 3; k++) begin
      chk("R5 dst addr", log_a[k], 16'h0301);
      chk("R5 data", log_d[k], s0 + 16'(k));
    end
    chk("R7 imm addr", log_a[3], 16'h0302);
    chk("R7 imm data", log_d[3], 16'hBEEF);
    chk("R5 src reads", src_reads, 3);
    exp_pwr = 8'h04;
    chk("R8 R4 pwr after end", pwr_en, exp_pwr);
    chk("R2 R8 busy", busy, 0);

    // R5 R6 count sweep on irq 1
    mem[1] = 16'h0040;
    mem[16'h41] = 16'h0300; mem[16'h42] = 16'h0301;
    mem[16'h43] = enc(5, 0); mem[16'h44] = 16'h0302;
    mem[16'h46] = enc(0, 0);
    for (int n = 0; n <= 6; n++) begin
      mem[16'h40] = enc(4, n);
      mem[16'h45] = 16'h5A00 + 16'(n);
      clear_log(); s0 = src_seq;
      fire(4'b0010); wait_idle();
      chk(n == 0 ? "R6 writes" : "R5 writes", log_n, n + 1);
      chk(n == 0 ? "R6 src reads" : "R5 src reads", src_reads, n);
      for (int k = 0; k < n; k++) chk("R5 data", log_d[k], s0 + 16'(k));
      chk("R6 R7 trailing write", log_d[n], 16'h5A00 + 16'(n));
    end

    // R4 power sweep on irq 2
    mem[2] = 16'h0060; mem[16'h61] = enc(0, 0);
    for (int d = 0; d < 8; d++) begin
      mem[16'h60] = enc(1, d);
      fire(4'b0100); wait_idle();
      exp_pwr[d] = 1'b1;
      chk("R4 on", pwr_en, exp_pwr);
    end
    for (int d = 7; d >= 0; d--) begin
      mem[16'h60] = enc(2, d);
      fire(4'b0100); wait_idle();
      exp_pwr[d] = 1'b0;
      chk("R4 off", pwr_en, exp_pwr);
    end

    // R3 priority: each routine writes its id
    for (int i = 0; i < 4; i++) begin
      mem[i] = 16'h0080 + 16'(8 * i);
      mem[16'h80 + 8 * i]     = enc(5, 0);
      mem[16'h81 + 8 * i]     = 16'h0302;
      mem[16'h82 + 8 * i]     = 16'hA0 + 16'(i);
      mem[16'h83 + 8 * i]     = enc(0, 0);
    end
    clear_log();
    fire(4'b1110); wait_idle();
    chk("R3 count", log_n, 3);
    for (int k = 0; k < 3; k++) chk("R3 order", log_d[k], 16'hA1 + 16'(k));
    clear_log();
    fire(4'b0100);
    repeat (2) @(negedge clk);
    fire(4'b1001); wait_idle();
    ids[0] = 16'hA2; ids[1] = 16'hA0; ids[2] = 16'hA3;
    chk("R3 no preempt count", log_n, 3);
    for (int k = 0; k < 3; k++) chk("R3 no preempt order", log_d[k], ids[k]);

    // R9 reserved opcodes on irq 3
    mem[3] = 16'h00C0;
    mem[16'hC0] = enc(1, 5); mem[16'hC2] = enc(1, 6); mem[16'hC3] = enc(0, 0);
    for (int r = 0; r < 3; r++) begin
      mem[16'hC1] = enc(r == 0 ? 3 : (r == 1 ? 6 : 7), 0);
      clear_log();
      fire(4'b1000); wait_idle();
      chk("R9 err set", err, 1);
      chk("R9 stops before next", pwr_en, 8'h20);
      chk("R9 busy", busy, 0);
      fire(4'b0001); wait_idle();
      chk("R9 err cleared", err, 0);
      chk("R9 clean routine ran", log_n, 1);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule